// File: doc/BRIEF.md
# I2C Event Flag and Clock-Hold Controller

This block sits between the bit-level engine of a combined master/slave I2C controller and the processor. Whenever the engine enters a defined protocol state, it presents a 5-bit state code. The block latches the code, raises an event flag and, as long as that flag stays up, holds the SCL line low so that the transfer pauses until software has serviced it. The one code that means "nothing to report" (all ones) leaves the flag alone. The processor reads the latched code through an 8-bit status value. It clears the flag by writing the flag bit as zero, and through that same write it can ask for a START, a STOP, or both.

The status value changes only on machine-cycle ticks. A fresh code therefore becomes visible at the first tick after the flag rises, and it stays visible until the first tick after the flag falls. After that the status returns to the idle pattern F8h. A request for STOP and START together issues the STOP first and the START one cycle later. In master mode that STOP goes onto the bus. In slave mode it is only an internal event. The interrupt output combines the flag with a global enable and a serial enable.

Top module: `i2c_event_flag_ctrl`

## Requirements
- R1: When the flag is low and `ev_valid` presents a code other than 5'h1F, the flag is high after the next clock edge and that code is latched.
- R2: A `ev_valid` with code 5'h1F neither sets the flag nor changes the latched code.
- R3: While the flag is high, further `ev_valid` events are ignored, and the latched code keeps its value.
- R4: The flag falls only after a control write with `ctl_flag` = 0. A control write with `ctl_flag` = 1 never raises the flag.
- R5: `status_o` is F8h after reset. Bits [2:0] always read 0. On each `mc_tick` edge, bits [7:3] load the latched code if the flag is high and 5'h1F if the flag is low. Between ticks, `status_o` is stable.
- R6: `scl_hold_o` is high after an edge where the flag's next value is high and `scl_in` is low. It never rises after an edge where `scl_in` was high, and it falls on the edge that clears the flag.
- R7: `irq_o` is high exactly when the flag, `en_global` and `en_serial` are all high.
- R8: A control write with both `ctl_stop` and `ctl_start` set while `is_master` = 1 pulses `bus_stop_o` in the next cycle and then pulses `start_o` in the cycle after.
- R9: The same write with `is_master` = 0 pulses `int_stop_o` instead of `bus_stop_o`, again followed one cycle later by `start_o`.
- R10: A control write with only `ctl_start` set pulses `start_o` in the next cycle. A write with only `ctl_stop` set pulses only the stop output that matches the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| ev_valid | input | 1 | Engine reports a state entry |
| ev_code | input | 5 | State code from the engine |
| is_master | input | 1 | Engine is in a master mode |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Write data: request START |
| ctl_stop | input | 1 | Write data: request STOP |
| ctl_flag | input | 1 | Write data: flag bit (0 clears) |
| en_global | input | 1 | Global interrupt enable |
| en_serial | input | 1 | Serial interrupt enable |
| scl_in | input | 1 | Sampled SCL line level |
| status_o | output | 8 | Status: code in [7:3], zeros in [2:0] |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Interrupt request |
| scl_hold_o | output | 1 | Pull SCL low |
| bus_stop_o | output | 1 | Pulse: drive STOP on the bus |
| int_stop_o | output | 1 | Pulse: internal STOP only |
| start_o | output | 1 | Pulse: generate START |

## Verification
A flag stuck in the wrong state is seen at the ports within one clock. `flag_o` and `irq_o` disagree with the model in the cycle after the triggering event, and `scl_hold_o` follows on the same edge whenever SCL is low. A latched code that is wrong, or a status update at the wrong time, stays hidden until the next `mc_tick`, at most one machine cycle later. A wrong pending START is caught one cycle after the STOP pulse.

// File: rtl/i2cfl_pkg.sv
package i2cfl_pkg;
    parameter int CODE_W_DEF = 5;
    parameter int STAT_W_DEF = 8;

    typedef struct packed {
        logic bus_stop;
        logic int_stop;
        logic start;
        logic pend_start;
    } cond_t;
endpackage

// File: rtl/i2cfl_flag_unit.sv
module i2cfl_flag_unit #(
    parameter int CODE_W = i2cfl_pkg::CODE_W_DEF,
    parameter int STAT_W = i2cfl_pkg::STAT_W_DEF,
    parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              clr_req,
    output logic              flag_o,
    output logic              flag_next_o,
    output logic [STAT_W-1:0] status_o
);
    localparam int PAD_W = STAT_W - CODE_W;
    localparam logic [STAT_W-1:0] IDLE_STAT = {IDLE_CODE, {PAD_W{1'b0}}};

    typedef struct packed {
        logic              flag;
        logic [CODE_W-1:0] code;
        logic [STAT_W-1:0] stat;
    } fs_t;

    fs_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = ev_valid && (ev_code != IDLE_CODE) && !st_q.flag;
        if (accept) begin
            st_d.flag = 1'b1;
            st_d.code = ev_code;
        end else if (st_q.flag && clr_req) begin
            st_d.flag = 1'b0;
        end
        if (mc_tick) begin
            st_d.stat = st_q.flag ? {st_q.code, {PAD_W{1'b0}}} : IDLE_STAT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
            st_q.code <= IDLE_CODE;
            st_q.stat <= IDLE_STAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o      = st_q.flag;
    assign flag_next_o = st_d.flag;
    assign status_o    = st_q.stat;
endmodule

// File: rtl/i2cfl_cond_seq.sv
module i2cfl_cond_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic req_start,
    input  logic req_stop,
    input  logic master,
    output logic bus_stop_o,
    output logic int_stop_o,
    output logic start_o
);
    import i2cfl_pkg::*;

    cond_t c_d, c_q;

    always_comb begin
        c_d = '0;
        if (wr) begin
            c_d.bus_stop   = req_stop && master;
            c_d.int_stop   = req_stop && !master;
            c_d.start      = c_q.pend_start || (req_start && !req_stop);
            c_d.pend_start = req_start && req_stop;
        end else begin
            c_d.start      = c_q.pend_start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bus_stop_o = c_q.bus_stop;
    assign int_stop_o = c_q.int_stop;
    assign start_o    = c_q.start;
endmodule

// File: rtl/i2cfl_bus_side.sv
module i2cfl_bus_side (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    input  logic flag_next,
    input  logic scl_in,
    input  logic en_global,
    input  logic en_serial,
    output logic scl_hold_o,
    output logic irq_o
);
    logic hold_d, hold_q;

    always_comb begin
        hold_d = flag_next && !scl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_d;
    end

    assign scl_hold_o = hold_q;
    assign irq_o      = flag && en_global && en_serial;
endmodule

// File: rtl/i2c_event_flag_ctrl.sv
module i2c_event_flag_ctrl #(
    parameter int CODE_W = i2cfl_pkg::CODE_W_DEF,
    parameter int STAT_W = i2cfl_pkg::STAT_W_DEF,
    parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              is_master,
    input  logic              ctl_wr,
    input  logic              ctl_start,
    input  logic              ctl_stop,
    input  logic              ctl_flag,
    input  logic              en_global,
    input  logic              en_serial,
    input  logic              scl_in,
    output logic [STAT_W-1:0] status_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic              scl_hold_o,
    output logic              bus_stop_o,
    output logic              int_stop_o,
    output logic              start_o
);
    logic flag_next;
    logic clr_req;

    assign clr_req = ctl_wr && !ctl_flag;

    i2cfl_flag_unit #(
        .CODE_W(CODE_W), .STAT_W(STAT_W), .IDLE_CODE(IDLE_CODE)
    ) u_flag (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .ev_valid(ev_valid), .ev_code(ev_code), .clr_req(clr_req),
        .flag_o(flag_o), .flag_next_o(flag_next), .status_o(status_o)
    );

    i2cfl_cond_seq u_cond (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr),
        .req_start(ctl_start), .req_stop(ctl_stop), .master(is_master),
        .bus_stop_o(bus_stop_o), .int_stop_o(int_stop_o), .start_o(start_o)
    );

    i2cfl_bus_side u_bus (
        .clk(clk), .rst_n(rst_n), .flag(flag_o), .flag_next(flag_next),
        .scl_in(scl_in), .en_global(en_global), .en_serial(en_serial),
        .scl_hold_o(scl_hold_o), .irq_o(irq_o)
    );
endmodule

// File: rtl/i2c_event_flag_ctrl_chk.sv
module i2c_event_flag_ctrl_chk #(
    parameter int CODE_W = 5,
    parameter int STAT_W = 8,
    parameter logic [CODE_W-1:0] IDLE_CODE = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_tick,
    input logic              ev_valid,
    input logic [CODE_W-1:0] ev_code,
    input logic              is_master,
    input logic              ctl_wr,
    input logic              ctl_start,
    input logic              ctl_stop,
    input logic              ctl_flag,
    input logic              scl_in,
    input logic [STAT_W-1:0] status_o,
    input logic              flag_o,
    input logic              scl_hold_o,
    input logic              bus_stop_o,
    input logic              int_stop_o,
    input logic              start_o
);
    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && ev_valid && ev_code != IDLE_CODE) |=> flag_o);

    assert_idle_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && ev_valid && ev_code == IDLE_CODE) |=> !flag_o);

    assert_sw_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> $past(ctl_wr && !ctl_flag));

    assert_stat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_tick |=> $stable(status_o));

    assert_hold_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold_o) |-> !$past(scl_in));

    assert_stop_then_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_start && ctl_stop && is_master) |=> bus_stop_o ##1 start_o);

    assert_slave_int_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_stop && !is_master) |=> (int_stop_o && !bus_stop_o));
endmodule

bind i2c_event_flag_ctrl i2c_event_flag_ctrl_chk #(
    .CODE_W(CODE_W), .STAT_W(STAT_W), .IDLE_CODE(IDLE_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ev_valid(ev_valid),
    .ev_code(ev_code), .is_master(is_master), .ctl_wr(ctl_wr),
    .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_flag(ctl_flag),
    .scl_in(scl_in), .status_o(status_o), .flag_o(flag_o),
    .scl_hold_o(scl_hold_o), .bus_stop_o(bus_stop_o),
    .int_stop_o(int_stop_o), .start_o(start_o)
);

// File: tb/i2c_event_flag_ctrl_tb.sv
module i2c_event_flag_ctrl_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, mc_tick, ev_valid, is_master, ctl_wr, ctl_start, ctl_stop, ctl_flag;
    logic       en_global, en_serial, ext_scl, scl_in;
    logic [4:0] ev_code;
    logic [7:0] status_o;
    logic       flag_o, irq_o, scl_hold_o, bus_stop_o, int_stop_o, start_o;

    assign scl_in = ext_scl & ~scl_hold_o;

    i2c_event_flag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .ev_valid(ev_valid),
        .ev_code(ev_code), .is_master(is_master), .ctl_wr(ctl_wr),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_flag(ctl_flag),
        .en_global(en_global), .en_serial(en_serial), .scl_in(scl_in),
        .status_o(status_o), .flag_o(flag_o), .irq_o(irq_o),
        .scl_hold_o(scl_hold_o), .bus_stop_o(bus_stop_o),
        .int_stop_o(int_stop_o), .start_o(start_o)
    );

    int errors = 0;
    int checks = 0;

    // Expected-behaviour model, derived from the requirements
    logic       m_flag, m_hold, m_bs, m_is, m_st, m_pend;
    logic [4:0] m_code;
    logic [7:0] m_stat;

    function automatic logic [7:0] stat_of(input logic f, input logic [4:0] c);
        return f ? {c, 3'b000} : 8'hF8;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flag = 0; m_code = 5'h1F; m_stat = 8'hF8; m_hold = 0;
            m_bs = 0; m_is = 0; m_st = 0; m_pend = 0;
        end else begin
            logic nf;
            logic sc;
            sc = ext_scl & ~m_hold;
            nf = m_flag;
            if (mc_tick) m_stat = stat_of(m_flag, m_code);
            if (!m_flag && ev_valid && ev_code != 5'h1F) begin
                nf = 1; m_code = ev_code;
            end else if (m_flag && ctl_wr && !ctl_flag) begin
                nf = 0;
            end
            m_flag = nf;
            m_hold = nf & ~sc;
            if (ctl_wr) begin
                m_bs = ctl_stop & is_master;
                m_is = ctl_stop & ~is_master;
                m_st = m_pend | (ctl_start & ~ctl_stop);
                m_pend = ctl_start & ctl_stop;
            end else begin
                m_bs = 0; m_is = 0; m_st = m_pend; m_pend = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R1/R3 flag", {31'd0, flag_o}, {31'd0, m_flag});
        chk("R5 status", {24'd0, status_o}, {24'd0, m_stat});
        chk("R6 scl hold", {31'd0, scl_hold_o}, {31'd0, m_hold});
        chk("R7 irq", {31'd0, irq_o}, {31'd0, m_flag & en_global & en_serial});
        chk("R8 bus stop", {31'd0, bus_stop_o}, {31'd0, m_bs});
        chk("R9 int stop", {31'd0, int_stop_o}, {31'd0, m_is});
        chk("R10 start", {31'd0, start_o}, {31'd0, m_st});
    endtask

    task automatic cyc();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic idle_in();
        mc_tick = 0; ev_valid = 0; ctl_wr = 0; ctl_start = 0; ctl_stop = 0; ctl_flag = 1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; idle_in(); ev_code = 0; is_master = 1;
        en_global = 1; en_serial = 1; ext_scl = 0;
        repeat (3) @(negedge clk);
        chk("R5 reset status", {24'd0, status_o}, 32'hF8);
        chk("R1 reset flag", {31'd0, flag_o}, 32'd0);
        rst_n = 1;
        cyc();
        // R2: idle code leaves flag low
        ev_valid = 1; ev_code = 5'h1F;
        cyc(); idle_in();
        chk("R2 idle code", {31'd0, flag_o}, 32'd0);
        // R1: real code sets flag; R6 hold with SCL low
        ev_valid = 1; ev_code = 5'h0C;
        cyc(); idle_in();
        chk("R1 set", {31'd0, flag_o}, 32'd1);
        chk("R6 hold", {31'd0, scl_hold_o}, 32'd1);
        // R3: second event ignored
        ev_valid = 1; ev_code = 5'h05;
        cyc(); idle_in();
        mc_tick = 1;
        cyc(); idle_in();
        chk("R3/R5 status code", {24'd0, status_o}, 32'h60);
        // R4: writing 1 does not clear, writing 0 clears
        ctl_wr = 1; ctl_flag = 1;
        cyc(); idle_in();
        chk("R4 write one", {31'd0, flag_o}, 32'd1);
        ctl_wr = 1; ctl_flag = 0;
        cyc(); idle_in();
        chk("R4 clear", {31'd0, flag_o}, 32'd0);
        chk("R5 status held", {24'd0, status_o}, 32'h60);
        mc_tick = 1;
        cyc(); idle_in();
        chk("R5 back to idle", {24'd0, status_o}, 32'hF8);
        // R8: master stop+start
        is_master = 1; ctl_wr = 1; ctl_stop = 1; ctl_start = 1;
        cyc(); idle_in();
        chk("R8 stop first", {31'd0, bus_stop_o}, 32'd1);
        cyc();
        chk("R8 then start", {31'd0, start_o}, 32'd1);
        // R9: slave stop+start
        is_master = 0; ctl_wr = 1; ctl_stop = 1; ctl_start = 1;
        cyc(); idle_in();
        chk("R9 internal stop", {31'd0, int_stop_o}, 32'd1);
        chk("R9 no bus stop", {31'd0, bus_stop_o}, 32'd0);
        cyc();
        chk("R9 then start", {31'd0, start_o}, 32'd1);
        // R10: start only
        ctl_wr = 1; ctl_start = 1;
        cyc(); idle_in();
        chk("R10 start only", {31'd0, start_o}, 32'd1);
        // R7: enables gate the interrupt
        ev_valid = 1; ev_code = 5'h11;
        cyc(); idle_in(); en_global = 0;
        cyc();
        chk("R7 masked", {31'd0, irq_o}, 32'd0);
        ctl_wr = 1; ctl_flag = 0;
        cyc(); idle_in();

        for (int i = 0; i < 4000; i++) begin
            mc_tick   = ($urandom % 4) == 0;
            ev_valid  = ($urandom % 5) == 0;
            ev_code   = (($urandom % 4) == 0) ? 5'h1F : 5'($urandom);
            ctl_wr    = ($urandom % 8) == 0;
            ctl_start = $urandom % 2 == 1;
            ctl_stop  = $urandom % 2 == 1;
            ctl_flag  = $urandom % 2 == 1;
            is_master = $urandom % 2 == 1;
            en_global = ($urandom % 4) != 0;
            en_serial = ($urandom % 4) != 0;
            if (($urandom % 6) == 0) ext_scl = ~ext_scl;
            cyc();
        end
        summary();
    end
endmodule